// File: doc/BRIEF.md
# Dual-Word Programmable Clock Divider

This block divides an input clock by a programmable ratio and marks each division period with a one-cycle terminal-count pulse. It keeps two 8-bit division words in two holding registers. Each register follows its input word while its own load strobe is high, and it keeps its value while the strobe is low. A select input decides which of the two words is copied into an 8-bit down counter each time the counter reaches zero. The ratio can therefore be changed on the fly, either by rewriting a word or by flipping the select. A change never shortens or stretches the period that is already running.

A clock enable freezes the counter and the output. A master reset clears everything at once, with its release brought into the clock domain by a short synchronizer. The terminal-count output comes from a register, so it trails the internal zero detect by one clock.

Top module: `dvd_dual_word`

## Requirements
- R1: While the internal reset is active, `tc` is low and both holding registers hold 0x00. After reset with no load, the divider therefore runs at ratio 1.
- R2: On each rising clock edge with `ld_a` high, holding register A takes `word_a`, and likewise register B with `ld_b` and `word_b`. With its strobe low, a register keeps its value whatever its input word does. This holds regardless of `ce`.
- R3: On an enabled edge, the counter decrements by one if it is not zero. If it is zero, it reloads.
- R4: With word value w, `tc` pulses once every w+1 enabled clocks. Word 0x00 keeps `tc` high on every enabled cycle, word 0x0B gives 12 clocks, and word 0xFF gives 256 clocks.
- R5: `tc` is registered. It is high in the cycle after an enabled edge at which the counter was zero, and low after any other enabled edge. For w ≥ 1 each pulse is therefore exactly one clock wide.
- R6: The reload takes the word chosen by `sel` at the reload edge: `sel`=0 takes register A and `sel`=1 takes register B. Flipping `sel` mid-period first affects the next period.
- R7: A write to either holding register during a period leaves the length of that period unchanged. The new word is used from the next reload on.
- R8: On an edge with `ce` low, both the counter and `tc` keep their values, and every enabled period is stretched by the number of stalled clocks.
- R9: The internal reset is released on the second rising edge after `rst_n` goes high. The third rising edge reloads the counter and raises `tc`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock to be divided |
| rst_n | input | 1 | Master reset, active low, asserted asynchronously |
| ce | input | 1 | Clock enable; low freezes counter and output |
| sel | input | 1 | Word select for the next reload (0 = A, 1 = B) |
| ld_a | input | 1 | Load strobe of holding register A |
| word_a | input | 8 | Division word A |
| ld_b | input | 1 | Load strobe of holding register B |
| word_b | input | 8 | Division word B |
| tc | output | 1 | Registered terminal-count pulse |

## Verification
Some rules are checked by assertions on every cycle:
- the decrement step;
- the choice of word at a reload and the `sel` value it uses;
- the freeze under a low enable;
- the capture and hold behaviour of both holding registers;
- the one-clock lag of `tc` behind the zero detect.

Other behaviour shows only across whole periods, so only the directed scenarios can show it:
- the pulse spacing for words 0x00, 0x01, 0x0B, 0xFF and a word taken from register B;
- a period that keeps its length through a mid-period rewrite;
- a `sel` flip that takes effect one period late;
- a stall that lengthens the gap by exactly the stalled clocks;
- the three-edge start after reset.

// File: rtl/dvd_pkg.sv
package dvd_pkg;
  localparam int unsigned DVD_WORD_W = 8;
  localparam int unsigned DVD_NUM_WORDS = 2;

  typedef enum logic {
    DVD_PICK_A = 1'b0,
    DVD_PICK_B = 1'b1
  } dvd_pick_e;
endpackage

// File: rtl/dvd_rst_sync.sv
module dvd_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/dvd_word_hold.sv
module dvd_word_hold #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] din,
  output logic [W-1:0] q
);
  logic [W-1:0] hold_q;
  logic [W-1:0] hold_d;

  always_comb begin
    hold_d = load ? din : hold_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hold_q <= '0;
    else        hold_q <= hold_d;
  end

  assign q = hold_q;
endmodule

// File: rtl/dvd_down_counter.sv
module dvd_down_counter
  import dvd_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  dvd_pick_e    pick,
  input  logic [W-1:0] word_a,
  input  logic [W-1:0] word_b,
  output logic [W-1:0] cnt,
  output logic         at_zero
);
  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;
  logic [W-1:0] reload_word;

  always_comb begin
    reload_word = (pick == DVD_PICK_B) ? word_b : word_a;
    cnt_d = cnt_q;
    if (en) begin
      if (cnt_q == '0) cnt_d = reload_word;
      else             cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt     = cnt_q;
  assign at_zero = (cnt_q == '0);
endmodule

// File: rtl/dvd_tc_retime.sv
module dvd_tc_retime (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic at_zero,
  output logic tc
);
  logic tc_q;
  logic tc_d;

  always_comb begin
    tc_d = en ? at_zero : tc_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tc_q <= 1'b0;
    else        tc_q <= tc_d;
  end

  assign tc = tc_q;
endmodule

// File: rtl/dvd_dual_word.sv
module dvd_dual_word
  import dvd_pkg::*;
#(
  parameter int unsigned W         = DVD_WORD_W,
  parameter int unsigned SYNC_DEPTH = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ce,
  input  logic         sel,
  input  logic         ld_a,
  input  logic [W-1:0] word_a,
  input  logic         ld_b,
  input  logic [W-1:0] word_b,
  output logic         tc
);
  localparam int unsigned NW = DVD_NUM_WORDS;

  logic                  rst_n_int;
  logic [NW-1:0]         ld_vec;
  logic [NW-1:0][W-1:0]  word_vec;
  logic [NW-1:0][W-1:0]  hold_vec;
  logic [W-1:0]          hold_a;
  logic [W-1:0]          hold_b;
  logic [W-1:0]          cnt;
  logic                  at_zero;
  dvd_pick_e             pick;

  dvd_rst_sync #(.STAGES(SYNC_DEPTH)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  assign ld_vec   = {ld_b, ld_a};
  assign word_vec = {word_b, word_a};

  for (genvar i = 0; i < NW; i++) begin : g_hold
    dvd_word_hold #(.W(W)) u_hold (
      .clk   (clk),
      .rst_n (rst_n_int),
      .load  (ld_vec[i]),
      .din   (word_vec[i]),
      .q     (hold_vec[i])
    );
  end

  assign hold_a = hold_vec[0];
  assign hold_b = hold_vec[1];
  assign pick   = sel ? DVD_PICK_B : DVD_PICK_A;

  dvd_down_counter #(.W(W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n_int),
    .en      (ce),
    .pick    (pick),
    .word_a  (hold_a),
    .word_b  (hold_b),
    .cnt     (cnt),
    .at_zero (at_zero)
  );

  dvd_tc_retime u_tc (
    .clk     (clk),
    .rst_n   (rst_n_int),
    .en      (ce),
    .at_zero (at_zero),
    .tc      (tc)
  );
endmodule

// File: rtl/dvd_dual_word_chk.sv
module dvd_dual_word_chk #(
  parameter int unsigned W = 8
) (
  input logic         clk,
  input logic         rst_n_int,
  input logic         ce,
  input logic         sel,
  input logic         ld_a,
  input logic [W-1:0] word_a,
  input logic         ld_b,
  input logic [W-1:0] word_b,
  input logic [W-1:0] hold_a,
  input logic [W-1:0] hold_b,
  input logic [W-1:0] cnt,
  input logic         tc
);
  // R1
  reset_tc_low_chk: assert property (@(posedge clk)
    !rst_n_int |-> !tc);

  // R2
  hold_a_load_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    ld_a |=> hold_a == $past(word_a));

  // R2
  hold_a_keep_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    !ld_a |=> $stable(hold_a));

  // R2
  hold_b_load_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    ld_b |=> hold_b == $past(word_b));

  // R2
  hold_b_keep_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    !ld_b |=> $stable(hold_b));

  // R3
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    (ce && cnt != '0) |=> cnt == $past(cnt) - 1'b1);

  // R6
  reload_pick_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    (ce && cnt == '0) |=> cnt == ($past(sel) ? $past(hold_b) : $past(hold_a)));

  // R5
  tc_lag_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    ce |=> tc == ($past(cnt) == '0));

  // R8
  stall_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    !ce |=> ($stable(cnt) && $stable(tc)));
endmodule

bind dvd_dual_word dvd_dual_word_chk #(.W(W)) u_chk (
  .clk       (clk),
  .rst_n_int (rst_n_int),
  .ce        (ce),
  .sel       (sel),
  .ld_a      (ld_a),
  .word_a    (word_a),
  .ld_b      (ld_b),
  .word_b    (word_b),
  .hold_a    (hold_a),
  .hold_b    (hold_b),
  .cnt       (cnt),
  .tc        (tc)
);

// File: tb/tb_dvd_dual_word.sv
module tb_dvd_dual_word;
  logic       clk;
  logic       rst_n;
  logic       ce;
  logic       sel;
  logic       ld_a;
  logic [7:0] word_a;
  logic       ld_b;
  logic [7:0] word_b;
  logic       tc;

  int n_checks = 0;
  int n_fails  = 0;
  localparam int GAP_LIMIT = 600;

  dvd_dual_word dut (
    .clk(clk), .rst_n(rst_n), .ce(ce), .sel(sel),
    .ld_a(ld_a), .word_a(word_a), .ld_b(ld_b), .word_b(word_b), .tc(tc)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic sync_tc();
    int n = 0;
    step();
    while (tc !== 1'b1 && n < GAP_LIMIT) begin
      step();
      n++;
    end
  endtask

  // from a sample with tc high, count samples until tc is high again
  task automatic measure(output int gap, output logic first);
    gap = 1;
    step();
    first = tc;
    while (tc !== 1'b1 && gap < GAP_LIMIT) begin
      step();
      gap++;
    end
  endtask

  task automatic program_a(input logic [7:0] w);
    step();
    word_a = w; ld_a = 1'b1;
    step();
    ld_a = 1'b0;
  endtask

  task automatic program_b(input logic [7:0] w);
    step();
    word_b = w; ld_b = 1'b1;
    step();
    ld_b = 1'b0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) begin
      step();
      check(tc === 1'b0, "R1 tc low in reset", int'(tc), 0);
    end
    rst_n = 1'b1;
    step();
    check(tc === 1'b0, "R9 edge1 after release", int'(tc), 0);
    step();
    check(tc === 1'b0, "R9 edge2 after release", int'(tc), 0);
    step();
    check(tc === 1'b1, "R9 first pulse at edge3", int'(tc), 1);
    repeat (3) begin
      step();
      check(tc === 1'b1, "R1 cleared words give ratio 1", int'(tc), 1);
    end
  endtask

  task automatic t_period(input logic [7:0] w, input bit use_b);
    int gap;
    logic first;
    sel = use_b;
    if (use_b) program_b(w);
    else       program_a(w);
    sync_tc();
    measure(gap, first);
    measure(gap, first);
    check(gap == int'(w) + 1, use_b ? "R4 R6 period from word B" : "R4 period from word A",
          gap, int'(w) + 1);
    if (w != 8'h00)
      check(first === 1'b0, "R5 pulse one clock wide", int'(first), 0);
  endtask

  task automatic t_rewrite();
    int gap;
    logic first;
    sel = 1'b0;
    program_a(8'h0B);
    sync_tc();
    measure(gap, first);
    gap = 0;
    step(); gap++;
    step(); gap++;
    word_a = 8'h02; ld_a = 1'b1;
    step(); gap++;
    ld_a = 1'b0;
    word_b = 8'h09; ld_b = 1'b1;
    step(); gap++;
    ld_b = 1'b0;
    while (tc !== 1'b1 && gap < GAP_LIMIT) begin
      step();
      gap++;
    end
    check(gap == 12, "R7 running period kept after rewrite", gap, 12);
    measure(gap, first);
    check(gap == 3, "R7 new word A used at next reload", gap, 3);
    word_a = 8'h07;
    measure(gap, first);
    check(gap == 3, "R2 word A ignored with strobe low", gap, 3);
  endtask

  task automatic t_sel();
    int gap;
    logic first;
    sel = 1'b0;
    program_a(8'h03);
    program_b(8'h06);
    sync_tc();
    measure(gap, first);
    step();
    sel = 1'b1;
    gap = 1;
    while (tc !== 1'b1 && gap < GAP_LIMIT) begin
      step();
      gap++;
    end
    check(gap == 4, "R6 sel flip waits for next reload", gap, 4);
    measure(gap, first);
    check(gap == 7, "R6 sel=1 picks word B", gap, 7);
    sel = 1'b0;
    measure(gap, first);
    check(gap == 7, "R6 sel=0 applies one period late", gap, 7);
    measure(gap, first);
    check(gap == 4, "R6 sel=0 picks word A", gap, 4);
  endtask

  task automatic t_ce();
    int gap;
    logic first;
    sel = 1'b0;
    program_a(8'h05);
    sync_tc();
    measure(gap, first);
    ce = 1'b0;
    repeat (3) begin
      step();
      check(tc === 1'b1, "R8 tc frozen high in stall", int'(tc), 1);
    end
    ce = 1'b1;
    gap = 3;
    step(); gap++;
    check(tc === 1'b0, "R8 count resumes after stall", int'(tc), 0);
    while (tc !== 1'b1 && gap < GAP_LIMIT) begin
      step();
      gap++;
    end
    check(gap == 9, "R8 stall stretches period", gap, 9);
    step();
    ce = 1'b0;
    program_a(8'h01);
    step();
    check(tc === 1'b0, "R8 tc frozen low in stall", int'(tc), 0);
    ce = 1'b1;
    sync_tc();
    measure(gap, first);
    measure(gap, first);
    check(gap == 2, "R2 load taken with ce low", gap, 2);
  endtask

  initial begin
    #(200000 * 8);
    n_fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; ce = 1'b1; sel = 1'b0;
    ld_a = 1'b0; ld_b = 1'b0; word_a = 8'h00; word_b = 8'h00;
    t_reset();
    t_period(8'h00, 1'b0);
    t_period(8'h01, 1'b0);
    t_period(8'h0B, 1'b0);
    t_period(8'hFF, 1'b0);
    t_period(8'h04, 1'b1);
    t_rewrite();
    t_sel();
    t_ce();
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end
endmodule